// File: doc/BRIEF.md
# Windowed Local Memory Access Bridge

This block gives a register-bus master a way into a large local SRAM through a narrow slice of its register space. The master first loads a 32-bit window base register, then issues word reads and writes anywhere inside a 2 KB aperture. The bridge keeps the page-selecting upper bits of the base and replaces everything below the page boundary with the offset the master used inside the aperture. One base value therefore reaches a full 2 KB page, and walking a large image means rewriting the base once per page.

A second register, the window data port, gives one-word access at the exact address held in the base register, with only the byte-lane bits dropped. The bridge accepts a request in every cycle. A read answers with a valid strobe and data exactly one cycle later. The local side is a plain synchronous SRAM port with one-cycle read latency. Addresses that land beyond the populated SRAM read as zero, and writes to them never reach the memory.

Top module: `wlm_bridge`

## Requirements
- R1: After reset the window base register holds zero, and no read response is signalled until a read request has been accepted.
- R2: The window base register at register offset 0x068 stores all 32 written bits. A read of it returns the stored value.
- R3: A request to register offsets 0x800 to 0xFFF reaches the SRAM byte address formed from base bits [31:11] above request offset bits [10:2], with two zero bits below. Base bits [10:0] have no effect on the address.
- R4: A request to the window data register at offset 0x068+4 (0x06C) reaches the SRAM byte address equal to the base register with bits [1:0] cleared.
- R5: Every read request is answered by the response-valid output in the following cycle and in no other cycle, with its data in that same cycle. Write requests produce no response.
- R6: A base register write changes the address used by a window or data-port request issued in the very next cycle.
- R7: A local byte address at or above the populated size (512 KB by default) reads as zero. A write to such an address leaves every SRAM word unchanged.
- R8: Register offsets that are neither the two registers nor the aperture read as zero. Writes to them change neither the base nor the SRAM.
- R9: Register address bits [1:0] are ignored, so all four byte offsets of a word select the same register or SRAM word.
- R10: Requests may arrive in consecutive cycles, each read receiving its own response in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register request strobe, accepted every cycle |
| reg_we | input | 1 | 1 = write request, 0 = read request |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read response valid, one cycle after a read |
| reg_rdata | output | 32 | Read response data, zero when not valid |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 17 | SRAM word address |
| sram_wdata | output | 32 | SRAM write data |
| sram_rdata | input | 32 | SRAM read data, valid the cycle after a read enable |

## Verification
Two functions that can land in one cycle are the return of a read and the acceptance of the next request. The sharpest case is a base register write in one cycle followed directly by an aperture access, whose response is then presented while yet another request is issued. The bench provokes this by issuing requests back to back with no idle cycles and by following base writes immediately with window and data-port accesses. A behavioural model predicts the response-valid and data outputs for every cycle, and each cycle is judged against them, so a late base update, a lost or duplicated response, or aliasing of an out-of-range write into populated memory shows up as a miscompare.

// File: rtl/wlm_pkg.sv
package wlm_pkg;

    localparam int DW = 32;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_BASE = 2'd1,
        TGT_DATA = 2'd2,
        TGT_APER = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_BASE = 2'd1,
        SRC_SRAM = 2'd2
    } rsp_src_e;

    typedef struct packed {
        logic [DW-1:0] base;
        logic          rvalid;
        rsp_src_e      src;
    } bridge_state_t;

endpackage

// File: rtl/wlm_decode.sv
module wlm_decode
    import wlm_pkg::*;
#(
    parameter int REG_AW     = 12,
    parameter int BASE_OFS   = 32'h068,
    parameter int DATA_OFS   = 32'h06C,
    parameter int APER_OFS   = 32'h800,
    parameter int APER_BYTES = 2048
) (
    input  logic [REG_AW-3:0] word_addr,
    output tgt_e              tgt
);
    localparam int APER_LSB = $clog2(APER_BYTES);
    localparam logic [REG_AW-1:0] BASE_A = REG_AW'(BASE_OFS);
    localparam logic [REG_AW-1:0] DATA_A = REG_AW'(DATA_OFS);
    localparam logic [REG_AW-1:0] APER_A = REG_AW'(APER_OFS);

    logic aper_hit;

    generate
        if (APER_LSB >= REG_AW) begin : g_aper_all
            assign aper_hit = 1'b1;
        end else begin : g_aper_slice
            assign aper_hit = (word_addr[REG_AW-3:APER_LSB-2] == APER_A[REG_AW-1:APER_LSB]);
        end
    endgenerate

    always_comb begin
        if (aper_hit) begin
            tgt = TGT_APER;
        end else if (word_addr == BASE_A[REG_AW-1:2]) begin
            tgt = TGT_BASE;
        end else if (word_addr == DATA_A[REG_AW-1:2]) begin
            tgt = TGT_DATA;
        end else begin
            tgt = TGT_NONE;
        end
    end

endmodule

// File: rtl/wlm_addr_gen.sv
module wlm_addr_gen
    import wlm_pkg::*;
#(
    parameter int MEM_BYTES  = 512 * 1024,
    parameter int APER_BYTES = 2048,
    localparam int APER_LSB  = $clog2(APER_BYTES),
    localparam int SRAM_AW   = $clog2(MEM_BYTES) - 2
) (
    input  tgt_e               tgt,
    input  logic [DW-3:0]      base_w,
    input  logic [APER_LSB-3:0] ofs_word,
    output logic               hit,
    output logic               in_range,
    output logic [SRAM_AW-1:0] word
);
    localparam logic [DW-3:0] MEM_WORDS = (DW-2)'(MEM_BYTES / 4);

    logic [DW-3:0] local_word;

    always_comb begin
        hit        = 1'b0;
        local_word = base_w;
        unique case (tgt)
            TGT_APER: begin
                hit        = 1'b1;
                local_word = {base_w[DW-3:APER_LSB-2], ofs_word};
            end
            TGT_DATA: begin
                hit        = 1'b1;
                local_word = base_w;
            end
            default: begin
                hit        = 1'b0;
                local_word = base_w;
            end
        endcase
        in_range = (local_word < MEM_WORDS);
        word     = local_word[SRAM_AW-1:0];
    end

endmodule

// File: rtl/wlm_bridge.sv
module wlm_bridge
    import wlm_pkg::*;
#(
    parameter int MEM_BYTES  = 512 * 1024,
    parameter int APER_BYTES = 2048,
    parameter int REG_AW     = 12,
    parameter int BASE_OFS   = 32'h068,
    parameter int DATA_OFS   = 32'h06C,
    parameter int APER_OFS   = 32'h800,
    localparam int APER_LSB  = $clog2(APER_BYTES),
    localparam int SRAM_AW   = $clog2(MEM_BYTES) - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_req,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic               reg_rvalid,
    output logic [DW-1:0]      reg_rdata,
    output logic               sram_en,
    output logic               sram_we,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [DW-1:0]      sram_wdata,
    input  logic [DW-1:0]      sram_rdata
);
    bridge_state_t st_d, st_q;
    tgt_e          tgt;
    logic          win_hit;
    logic          win_in_range;
    logic [SRAM_AW-1:0] win_word;
    logic          rd_req;
    logic          unused_lsbs;

    assign unused_lsbs = ^reg_addr[1:0];
    assign rd_req      = reg_req & ~reg_we;

    wlm_decode #(
        .REG_AW    (REG_AW),
        .BASE_OFS  (BASE_OFS),
        .DATA_OFS  (DATA_OFS),
        .APER_OFS  (APER_OFS),
        .APER_BYTES(APER_BYTES)
    ) decode_i (
        .word_addr(reg_addr[REG_AW-1:2]),
        .tgt      (tgt)
    );

    wlm_addr_gen #(
        .MEM_BYTES (MEM_BYTES),
        .APER_BYTES(APER_BYTES)
    ) addr_gen_i (
        .tgt     (tgt),
        .base_w  (st_q.base[DW-1:2]),
        .ofs_word(reg_addr[APER_LSB-1:2]),
        .hit     (win_hit),
        .in_range(win_in_range),
        .word    (win_word)
    );

    // next-state computation
    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_req;
        st_d.src    = SRC_ZERO;
        if (rd_req) begin
            unique case (tgt)
                TGT_BASE: st_d.src = SRC_BASE;
                TGT_DATA,
                TGT_APER: st_d.src = win_in_range ? SRC_SRAM : SRC_ZERO;
                default:  st_d.src = SRC_ZERO;
            endcase
        end
        if (reg_req && reg_we && (tgt == TGT_BASE)) begin
            st_d.base = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{base: '0, rvalid: 1'b0, src: SRC_ZERO};
        end else begin
            st_q <= st_d;
        end
    end

    // local memory port
    always_comb begin
        sram_en    = reg_req & win_hit & win_in_range;
        sram_we    = sram_en & reg_we;
        sram_addr  = win_word;
        sram_wdata = reg_wdata;
    end

    // response path
    always_comb begin
        reg_rvalid = st_q.rvalid;
        reg_rdata  = '0;
        if (st_q.rvalid) begin
            unique case (st_q.src)
                SRC_BASE: reg_rdata = st_q.base;
                SRC_SRAM: reg_rdata = sram_rdata;
                default:  reg_rdata = '0;
            endcase
        end
    end

    // R5
    rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we) |=> reg_rvalid);

    // R5
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && !reg_we) |=> !reg_rvalid);

    // R6
    base_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && (tgt == TGT_BASE)) |=> (st_q.base == $past(reg_wdata)));

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we && (tgt == TGT_NONE)) |=> (reg_rdata == '0));

    // R7
    sram_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_en |-> (reg_req && win_in_range));

    // R8
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && reg_we && (tgt == TGT_BASE)) |=> $stable(st_q.base));

endmodule

// File: tb/wlm_bridge_tb_top.sv
`timescale 1ns/1ps
module wlm_bridge_tb_top;
    localparam int MEM_BYTES = 512 * 1024;
    localparam int SRAM_AW   = 17;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_req = 1'b0;
    logic               reg_we = 1'b0;
    logic [11:0]        reg_addr = '0;
    logic [31:0]        reg_wdata = '0;
    logic               reg_rvalid;
    logic [31:0]        reg_rdata;
    logic               sram_en;
    logic               sram_we;
    logic [SRAM_AW-1:0] sram_addr;
    logic [31:0]        sram_wdata;
    logic [31:0]        sram_rdata = '0;

    always #2.5 clk = ~clk;

    wlm_bridge dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rvalid(reg_rvalid),
        .reg_rdata (reg_rdata),
        .sram_en   (sram_en),
        .sram_we   (sram_we),
        .sram_addr (sram_addr),
        .sram_wdata(sram_wdata),
        .sram_rdata(sram_rdata)
    );

    function automatic logic [31:0] pat(input int w);
        return 32'hA500_0000 ^ 32'(w);
    endfunction

    // synchronous SRAM model
    logic [31:0] sram_mem [int];
    always @(posedge clk) begin
        if (sram_en) begin
            if (sram_we) sram_mem[int'(sram_addr)] = sram_wdata;
            else sram_rdata <= sram_mem.exists(int'(sram_addr)) ? sram_mem[int'(sram_addr)]
                                                                 : pat(int'(sram_addr));
        end
    end

    // behavioural reference
    logic [31:0] ref_mem [int];
    logic [31:0] ref_base = '0;
    logic        exp_valid = 1'b0;
    logic [31:0] exp_data = '0;
    string       exp_tag = "R1";
    int          vectors = 0;
    int          miscompares = 0;

    task automatic check_now();
        vectors++;
        if (reg_rvalid !== exp_valid || (exp_valid && reg_rdata !== exp_data)) begin
            miscompares++;
            $display("FAIL %s: rvalid=%0b rdata=%08h expected rvalid=%0b rdata=%08h",
                     exp_tag, reg_rvalid, reg_rdata, exp_valid, exp_data);
        end
    endtask

    task automatic predict(input bit rq, input bit we, input logic [11:0] a,
                           input logic [31:0] d, input string tag);
        longint lb;
        int     kind;
        exp_valid = rq && !we;
        exp_data  = '0;
        exp_tag   = tag;
        if (!rq) return;
        lb = 0;
        if (a[11]) begin
            kind = 2;
            lb = longint'({ref_base[31:11], a[10:2], 2'b00});
        end else if (a[11:2] == 10'h01A) begin
            kind = 1;
        end else if (a[11:2] == 10'h01B) begin
            kind = 2;
            lb = longint'({ref_base[31:2], 2'b00});
        end else begin
            kind = 0;
        end
        if (!we) begin
            if (kind == 1) exp_data = ref_base;
            else if (kind == 2 && lb < MEM_BYTES)
                exp_data = ref_mem.exists(int'(lb >> 2)) ? ref_mem[int'(lb >> 2)] : pat(int'(lb >> 2));
        end else begin
            if (kind == 1) ref_base = d;
            else if (kind == 2 && lb < MEM_BYTES) ref_mem[int'(lb >> 2)] = d;
        end
    endtask

    task automatic step(input bit rq, input bit we, input logic [11:0] a,
                        input logic [31:0] d, input string tag);
        @(negedge clk);
        check_now();
        reg_req   = rq;
        reg_we    = we;
        reg_addr  = a;
        reg_wdata = d;
        predict(rq, we, a, d, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        step(1'b1, 1'b0, a, '0, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, '0, '0, tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R1: quiet during reset
        repeat (3) begin
            @(negedge clk);
            vectors++;
            if (reg_rvalid !== 1'b0 || sram_en !== 1'b0) begin
                miscompares++;
                $display("FAIL R1: rvalid=%0b sram_en=%0b expected 0 0", reg_rvalid, sram_en);
            end
        end
        rst_n = 1'b1;
        idle("R1");
        rd(12'h068, "R1");
        idle("R1");

        // R2: base register read back
        wr(12'h068, 32'hDEAD_BEEF, "R2");
        rd(12'h068, "R2");
        wr(12'h068, 32'h0000_1A5F, "R2");
        rd(12'h068, "R2");

        // R3 + R6: page bits only, new base used next cycle
        wr(12'h068, 32'h0001_2345, "R6");
        wr(12'h804, 32'h1111_0804, "R6");
        rd(12'h804, "R3");
        rd(12'hFFC, "R3");
        wr(12'h800, 32'h2222_0800, "R3");
        wr(12'h068, 32'h0001_2000, "R3");
        rd(12'h800, "R3");
        rd(12'h804, "R3");

        // R4: data port at exact base, bits [1:0] dropped
        wr(12'h068, 32'h0001_2006, "R4");
        wr(12'h06C, 32'h3333_2004, "R4");
        rd(12'h06C, "R4");
        wr(12'h068, 32'h0001_2000, "R6");
        rd(12'h804, "R4");
        rd(12'h06C, "R4");

        // R9: byte offset bits ignored
        wr(12'h80B, 32'h4444_0808, "R9");
        rd(12'h808, "R9");
        rd(12'h80A, "R9");
        rd(12'h069, "R9");
        rd(12'h06F, "R9");

        // R7: beyond populated size
        wr(12'h068, 32'h0008_0000, "R7");
        wr(12'h800, 32'h5555_5555, "R7");
        rd(12'h800, "R7");
        wr(12'h068, 32'h0000_0000, "R7");
        rd(12'h800, "R7");
        wr(12'h068, 32'h0007_F800, "R7");
        rd(12'hFFC, "R7");
        wr(12'hFFC, 32'h6666_FFFC, "R7");
        rd(12'hFFC, "R7");
        wr(12'h068, 32'hFFFF_FFFC, "R7");
        wr(12'h06C, 32'h7777_7777, "R7");
        rd(12'h06C, "R7");
        wr(12'h068, 32'h0007_FFFC, "R7");
        rd(12'h06C, "R7");

        // R8: unmapped offsets
        wr(12'h070, 32'h8888_8888, "R8");
        wr(12'h7FC, 32'h9999_9999, "R8");
        wr(12'h000, 32'hAAAA_AAAA, "R8");
        rd(12'h068, "R8");
        rd(12'h070, "R8");
        rd(12'h7FC, "R8");
        rd(12'h06C, "R8");
        idle("R8");

        // R10: back-to-back, then mixed random traffic
        wr(12'h068, 32'h0000_0800, "R10");
        wr(12'h800, 32'h0BAD_0000, "R10");
        wr(12'h804, 32'h0BAD_0001, "R10");
        rd(12'h800, "R10");
        rd(12'h804, "R10");
        rd(12'h808, "R10");
        rd(12'h068, "R10");
        rd(12'h06C, "R10");
        for (int i = 0; i < 400; i++) begin
            int unsigned k;
            logic [31:0] v;
            k = $urandom_range(0, 9);
            v = $urandom;
            case (k)
                0: wr(12'h068, (k == 0 && v[3]) ? (32'h0007_E000 + (v & 32'h3FFF))
                                                 : (v & 32'h0000_1FFF), "R10");
                1: wr(12'h068, 32'h0008_0000 | (v & 32'hFFF), "R10");
                2, 3: wr(12'h800 | 12'(v[10:0]), $urandom, "R10");
                4, 5, 6: rd(12'h800 | 12'(v[20:10]), "R10");
                7: rd(12'h06C | 12'(v[1:0]), "R10");
                8: wr(12'h06C, $urandom, "R10");
                default: if (v[0]) rd(12'h068, "R10"); else idle("R10");
            endcase
        end
        idle("R10");
        idle("R10");
        finish_run();
    end

endmodule